// File: doc/BRIEF.md
# Cache-line burst memory responder

This block is the system-side responder for a 64-bit processor front bus. A requester opens a cycle with a one-clock address strobe. Along with the strobe it gives a quadword address, eight byte enables, a write flag and a cacheable hint. The responder chooses how many beats the cycle has. For reads it tells the requester whether the cycle became a cache-line fill by driving a cache-enable line with the first ready. It drives ready once per beat, after a fixed latency, and runs a simple synchronous memory array with one clock of read latency.

A read turns into a four-beat line fill only when two conditions hold: the requester marks the read cacheable, and its quadword address lies inside a cacheable window set by parameters. Any other read is a single beat, and on that beat only the enabled bytes carry data. Cacheable writes are four-beat line writebacks. Non-cacheable writes are single beats that update only the enabled bytes.

On a burst, the responder itself works out the beat addresses from the starting address, in interleaved order. The byte enables are latched with the strobe. During a burst they are ignored and every beat moves all eight bytes. A strobe that arrives while a cycle is still running is ignored and raises a protocol-error pulse.

Top module: `line_burst_responder`

## Requirements
- R1: While reset is asserted, and after it is released until the first strobe, ready, cache-enable, protocol-error and memory-enable are all low. Asserting reset in the middle of a cycle drops ready at once.
- R2: When a strobe is accepted at clock edge n, ready is low in the clock that follows edge n and high in the clock that follows edge n+1. The requester therefore samples the first ready at edge n+2.
- R3: A read with the cacheable hint high and an address inside the window is a burst. It gives exactly four ready clocks in a row, and cache-enable is high during the first of them only.
- R4: Beat k of a burst (k = 0..3) uses the starting quadword address with its two low bits (byte-address bits 4:3) XORed with k. A start at quadword 1 gives 1, 0, 3, 2.
- R5: On every beat of a burst read, all eight bytes of the memory word are returned, whatever the byte enables are.
- R6: A read that is not a burst gives exactly one ready clock with cache-enable low. In the returned data, byte i (bits 8i+7:8i) is zero when enable bit i is low, and equals the memory byte when it is high.
- R7: The cacheable window covers the byte addresses from WIN_LO to WIN_HI inclusive (default 0x40 to 0x13F, that is quadwords 8 to 39). A cacheable read outside the window is a single transfer.
- R8: A write with the cacheable hint high is a four-beat burst whether or not it is inside the window. Each beat writes all eight bytes of the write data to the R4 address of that beat, and cache-enable stays low.
- R9: A write with the cacheable hint low is a single beat that changes only the memory bytes whose enable bit is high.
- R10: The byte enables and the cacheable hint are captured with the strobe. Changing them while the cycle runs has no effect on the data or the beat count.
- R11: A strobe seen while a cycle is in progress, including during its last ready, is ignored. Protocol-error is then high for the one following clock, and the cycle in progress keeps its beat count and addresses.
- R12: A strobe given in the clock right after the last ready is accepted as a new cycle with no protocol error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| req_strobe_i | input | 1 | Address strobe, one clock per cycle |
| req_qaddr_i | input | QA_W (29) | Quadword address (byte address bits 31:3) |
| req_be_i | input | BE_W (8) | Byte enables, bit i selects byte i |
| req_write_i | input | 1 | 1 = write cycle, 0 = read cycle |
| req_cacheable_i | input | 1 | Cacheable hint from the requester |
| req_wdata_i | input | DATA_W (64) | Write data, valid during each write ready clock |
| rsp_ready_o | output | 1 | One clock per completed beat |
| rsp_cache_en_o | output | 1 | High with the first ready of a line fill |
| rsp_rdata_o | output | DATA_W (64) | Read data, valid while ready is high |
| proto_err_o | output | 1 | Pulse after a strobe that arrived during a busy cycle |
| mem_en_o | output | 1 | Memory access enable |
| mem_we_o | output | 1 | Memory write enable |
| mem_addr_o | output | QA_W (29) | Memory quadword address |
| mem_be_o | output | BE_W (8) | Memory byte write enables |
| mem_wdata_o | output | DATA_W (64) | Memory write data |
| mem_rdata_i | input | DATA_W (64) | Memory read data, one clock after the access |

## Verification
The main decision is tried with reads that vary in three ways: the hint on or off, addresses just inside and just outside both window edges, and starting offsets of 0 to 3 within a line. This separates a window comparison that is off by one from a decision that ignores the hint. Byte-enable patterns include all-zero, all-one and sparse masks. These show whether the masks are honoured on single transfers but not during bursts. The bench also flips the enables and the hint right after every strobe, which shows whether they were captured or read live. A cacheable write outside the window tells the write rule apart from the read rule. A read-back line after a masked single write, a strobe injected mid-burst and a reset mid-burst cover the remaining corners.

// File: rtl/lbr_pkg.sv
package lbr_pkg;

  localparam int LINE_BEATS = 4;
  localparam int BEAT_W     = $clog2(LINE_BEATS);

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_BEAT = 2'd2
  } lbr_state_e;

  // interleaved beat order: beat index XORed into the low quadword bits
  function automatic logic [BEAT_W-1:0] il_offset(
    input logic [BEAT_W-1:0] start,
    input logic [BEAT_W-1:0] beat
  );
    return start ^ beat;
  endfunction

endpackage

// File: rtl/lbr_window.sv
module lbr_window #(
  parameter int ADDR_W = 32,
  parameter int OFS_W  = 3,
  parameter logic [ADDR_W-1:0] WIN_LO = 32'h0000_0040,
  parameter logic [ADDR_W-1:0] WIN_HI = 32'h0000_013F
) (
  input  logic [ADDR_W-OFS_W-1:0] qaddr_i,
  output logic                    in_win_o
);

  localparam int QA_W = ADDR_W - OFS_W;
  localparam logic [QA_W-1:0] LO_Q = WIN_LO[ADDR_W-1:OFS_W];
  localparam logic [QA_W-1:0] HI_Q = WIN_HI[ADDR_W-1:OFS_W];

  logic above_lo;
  logic below_hi;

  always_comb begin
    above_lo = (qaddr_i >= LO_Q);
    below_hi = (qaddr_i <= HI_Q);
    in_win_o = above_lo && below_hi;
  end

endmodule

// File: rtl/lbr_seq_ctrl.sv
module lbr_seq_ctrl
  import lbr_pkg::*;
#(
  parameter int LATENCY = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              strobe_i,
  input  logic              write_i,
  input  logic              cacheable_i,
  input  logic              in_win_i,
  output logic              accept_o,
  output logic              wait_last_o,
  output logic              rdy_o,
  output logic              last_o,
  output logic              cen_o,
  output logic              err_o,
  output logic              burst_o,
  output logic              write_o,
  output logic [BEAT_W-1:0] beat_o
);

  // LATENCY must be at least 2 so a read can be issued one clock ahead
  localparam int LAT_W = (LATENCY > 2) ? $clog2(LATENCY - 1) : 1;
  localparam logic [LAT_W-1:0]  LAT_END   = LAT_W'(LATENCY - 2);
  localparam logic [BEAT_W-1:0] BEAT_LAST = BEAT_W'(LINE_BEATS - 1);

  lbr_state_e        state_q, state_d;
  logic [LAT_W-1:0]  lat_q, lat_d;
  logic [BEAT_W-1:0] beat_q, beat_d;
  logic              burst_q, burst_d;
  logic              wr_q, wr_d;
  logic              err_q, err_d;
  logic              busy;
  logic              ctx_en;
  logic              lat_done;

  always_comb begin
    busy     = (state_q != ST_IDLE);
    accept_o = strobe_i && !busy;
    ctx_en   = accept_o;
    lat_done = (lat_q == LAT_END);
    rdy_o    = (state_q == ST_BEAT);
    last_o   = !burst_q || (beat_q == BEAT_LAST);
  end

  // next-state process
  always_comb begin
    state_d = state_q;
    lat_d   = lat_q;
    beat_d  = beat_q;
    burst_d = cacheable_i && (write_i || in_win_i);
    wr_d    = write_i;
    err_d   = strobe_i && busy;
    case (state_q)
      ST_IDLE: begin
        if (accept_o) begin
          state_d = ST_WAIT;
          lat_d   = '0;
          beat_d  = '0;
        end
      end
      ST_WAIT: begin
        if (lat_done) begin
          state_d = ST_BEAT;
        end else begin
          lat_d = lat_q + 1'b1;
        end
      end
      ST_BEAT: begin
        if (last_o) begin
          state_d = ST_IDLE;
        end else begin
          beat_d = beat_q + 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // register process
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      lat_q   <= '0;
      beat_q  <= '0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      lat_q   <= lat_d;
      beat_q  <= beat_d;
      err_q   <= err_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      burst_q <= 1'b0;
      wr_q    <= 1'b0;
    end else if (ctx_en) begin
      burst_q <= burst_d;
      wr_q    <= wr_d;
    end
  end

  always_comb begin
    wait_last_o = (state_q == ST_WAIT) && lat_done;
    cen_o       = rdy_o && (beat_q == '0) && burst_q && !wr_q;
    err_o       = err_q;
    burst_o     = burst_q;
    write_o     = wr_q;
    beat_o      = beat_q;
  end

  // R3
  burst_consec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rdy_o && !last_o) |=> rdy_o);

  // R3
  cen_lead_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cen_o |-> (rdy_o && !$past(rdy_o)));

  // R11
  proto_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe_i && busy) |=> (err_o && !$past(accept_o)));

  generate
    if (LATENCY == 2) begin : g_lat2
      // R2
      first_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        accept_o |=> (!rdy_o ##1 rdy_o));
    end
  endgenerate

endmodule

// File: rtl/lbr_addr_gen.sv
module lbr_addr_gen
  import lbr_pkg::*;
#(
  parameter int QA_W = 29,
  parameter int BE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept_i,
  input  logic [QA_W-1:0]   qaddr_i,
  input  logic [BE_W-1:0]   be_i,
  input  logic              write_i,
  input  logic              burst_i,
  input  logic              wait_last_i,
  input  logic              rdy_i,
  input  logic              last_i,
  input  logic [BEAT_W-1:0] beat_i,
  output logic              mem_en_o,
  output logic              mem_we_o,
  output logic [QA_W-1:0]   mem_addr_o,
  output logic [BE_W-1:0]   mem_be_o,
  output logic [8*BE_W-1:0] rd_mask_o
);

  localparam int DATA_W = 8 * BE_W;

  logic [QA_W-1:0]   base_q;
  logic [BE_W-1:0]   be_q;
  logic              cap_en;
  logic [BEAT_W-1:0] mem_idx;
  logic [DATA_W-1:0] be_mask;

  assign cap_en = accept_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      be_q   <= '0;
    end else if (cap_en) begin
      base_q <= qaddr_i;
      be_q   <= be_i;
    end
  end

  generate
    for (genvar g = 0; g < BE_W; g++) begin : g_mask
      assign be_mask[8*g +: 8] = {8{be_q[g]}};
    end
  endgenerate

  // reads look one beat ahead to cover the memory latency; writes use the current beat
  always_comb begin
    if (write_i) begin
      mem_idx  = beat_i;
      mem_en_o = rdy_i;
    end else if (wait_last_i) begin
      mem_idx  = '0;
      mem_en_o = 1'b1;
    end else begin
      mem_idx  = beat_i + 1'b1;
      mem_en_o = rdy_i && !last_i;
    end
    mem_we_o   = write_i && rdy_i;
    mem_addr_o = {base_q[QA_W-1:BEAT_W], il_offset(base_q[BEAT_W-1:0], mem_idx)};
    mem_be_o   = burst_i ? {BE_W{1'b1}} : be_q;
    rd_mask_o  = burst_i ? {DATA_W{1'b1}} : be_mask;
  end

  // R4
  beat_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rdy_i && !last_i && write_i) |=>
      (mem_addr_o[BEAT_W-1:0] != $past(mem_addr_o[BEAT_W-1:0])));

endmodule

// File: rtl/line_burst_responder.sv
module line_burst_responder
  import lbr_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int DATA_W  = 64,
  parameter int LATENCY = 2,
  parameter logic [ADDR_W-1:0] WIN_LO = 32'h0000_0040,
  parameter logic [ADDR_W-1:0] WIN_HI = 32'h0000_013F,
  localparam int BE_W  = DATA_W / 8,
  localparam int OFS_W = $clog2(BE_W),
  localparam int QA_W  = ADDR_W - OFS_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_strobe_i,
  input  logic [QA_W-1:0]   req_qaddr_i,
  input  logic [BE_W-1:0]   req_be_i,
  input  logic              req_write_i,
  input  logic              req_cacheable_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  output logic              rsp_ready_o,
  output logic              rsp_cache_en_o,
  output logic [DATA_W-1:0] rsp_rdata_o,
  output logic              proto_err_o,
  output logic              mem_en_o,
  output logic              mem_we_o,
  output logic [QA_W-1:0]   mem_addr_o,
  output logic [BE_W-1:0]   mem_be_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  input  logic [DATA_W-1:0] mem_rdata_i
);

  logic [1:0]        rst_sync_q;
  logic              core_rst_n;
  logic              in_win;
  logic              accept;
  logic              wait_last;
  logic              last_beat;
  logic              burst;
  logic              wr_cyc;
  logic [BEAT_W-1:0] beat;
  logic [DATA_W-1:0] rd_mask;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign core_rst_n = rst_sync_q[1];

  lbr_window #(
    .ADDR_W (ADDR_W),
    .OFS_W  (OFS_W),
    .WIN_LO (WIN_LO),
    .WIN_HI (WIN_HI)
  ) u_window (
    .qaddr_i  (req_qaddr_i),
    .in_win_o (in_win)
  );

  lbr_seq_ctrl #(
    .LATENCY (LATENCY)
  ) u_seq (
    .clk         (clk),
    .rst_n       (core_rst_n),
    .strobe_i    (req_strobe_i),
    .write_i     (req_write_i),
    .cacheable_i (req_cacheable_i),
    .in_win_i    (in_win),
    .accept_o    (accept),
    .wait_last_o (wait_last),
    .rdy_o       (rsp_ready_o),
    .last_o      (last_beat),
    .cen_o       (rsp_cache_en_o),
    .err_o       (proto_err_o),
    .burst_o     (burst),
    .write_o     (wr_cyc),
    .beat_o      (beat)
  );

  lbr_addr_gen #(
    .QA_W (QA_W),
    .BE_W (BE_W)
  ) u_addr (
    .clk         (clk),
    .rst_n       (core_rst_n),
    .accept_i    (accept),
    .qaddr_i     (req_qaddr_i),
    .be_i        (req_be_i),
    .write_i     (wr_cyc),
    .burst_i     (burst),
    .wait_last_i (wait_last),
    .rdy_i       (rsp_ready_o),
    .last_i      (last_beat),
    .beat_i      (beat),
    .mem_en_o    (mem_en_o),
    .mem_we_o    (mem_we_o),
    .mem_addr_o  (mem_addr_o),
    .mem_be_o    (mem_be_o),
    .rd_mask_o   (rd_mask)
  );

  always_comb begin
    mem_wdata_o = req_wdata_i;
    rsp_rdata_o = (rsp_ready_o && !wr_cyc) ? (mem_rdata_i & rd_mask) : '0;
  end

endmodule

// File: tb/sim_line_burst_responder.sv
`timescale 1ns/1ps
module sim_line_burst_responder;

  localparam int QA_W = 29;

  logic        clk;
  logic        rst_n;
  logic        strobe;
  logic [28:0] qaddr;
  logic [7:0]  be;
  logic        wr;
  logic        ca;
  logic [63:0] wdata;
  logic        rdy, cen, perr;
  logic [63:0] rdata;
  logic        m_en, m_we;
  logic [28:0] m_addr;
  logic [7:0]  m_be;
  logic [63:0] m_wdata;
  logic [63:0] m_rdata;

  logic [63:0] mem [64];
  int nchk = 0;
  int nfail = 0;

  line_burst_responder u0 (
    .clk (clk), .rst_n (rst_n),
    .req_strobe_i (strobe), .req_qaddr_i (qaddr), .req_be_i (be),
    .req_write_i (wr), .req_cacheable_i (ca), .req_wdata_i (wdata),
    .rsp_ready_o (rdy), .rsp_cache_en_o (cen), .rsp_rdata_o (rdata),
    .proto_err_o (perr),
    .mem_en_o (m_en), .mem_we_o (m_we), .mem_addr_o (m_addr),
    .mem_be_o (m_be), .mem_wdata_o (m_wdata), .mem_rdata_i (m_rdata)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  // synchronous memory, one clock read latency, byte-masked writes
  always @(posedge clk) begin
    if (m_en && m_we) begin
      for (int b = 0; b < 8; b++)
        if (m_be[b]) mem[m_addr[5:0]][8*b +: 8] <= m_wdata[8*b +: 8];
    end else if (m_en) begin
      m_rdata <= mem[m_addr[5:0]];
    end
  end

  typedef struct packed {
    logic [5:0] qa;
    logic [7:0] be;
    logic       wr;
    logic       ca;
  } vec_t;

  localparam vec_t VECS [10] = '{
    '{6'h09, 8'h0F, 1'b0, 1'b1},  // burst read, start offset 1
    '{6'h26, 8'h81, 1'b0, 1'b1},  // burst read, offset 2
    '{6'h27, 8'hFF, 1'b0, 1'b1},  // top window edge, offset 3
    '{6'h28, 8'h3C, 1'b0, 1'b1},  // just above window
    '{6'h07, 8'hF0, 1'b0, 1'b1},  // just below window
    '{6'h08, 8'h00, 1'b0, 1'b1},  // bottom edge, no enables
    '{6'h12, 8'h5A, 1'b0, 1'b0},  // non-cacheable read
    '{6'h31, 8'h00, 1'b1, 1'b1},  // writeback outside window
    '{6'h0B, 8'hF0, 1'b1, 1'b0},  // single masked write
    '{6'h0A, 8'hFF, 1'b0, 1'b1}   // line read-back
  };

  function automatic logic [63:0] mask64(input logic [7:0] m);
    logic [63:0] r;
    for (int b = 0; b < 8; b++) r[8*b +: 8] = {8{m[b]}};
    return r;
  endfunction

  function automatic bit in_window(input logic [5:0] q);
    return (q >= 6'd8) && (q <= 6'd39);
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // one bus cycle; entered and left at a falling edge
  task automatic run_cyc(input logic [5:0] qa, input logic [7:0] bev, input logic w,
                         input logic c, input int inj);
    bit          burst;
    int          nb;
    logic [5:0]  ba;
    logic [5:0]  wa [4];
    logic [63:0] we [4];
    logic [63:0] wd;
    string       tg;
    burst = c && (w || in_window(qa));
    nb = burst ? 4 : 1;
    tg = burst ? (w ? "R8" : "R3") : (w ? "R9" : "R6");
    strobe = 1'b1; qaddr = {23'd0, qa}; be = bev; wr = w; ca = c; wdata = '0;
    @(negedge clk);
    strobe = 1'b0; be = ~bev; ca = ~c;   // R10: changes after capture
    chk("R2 no ready in latency clock", {63'd0, rdy}, 64'd1 - 64'd1);
    @(negedge clk);
    for (int k = 0; k < nb; k++) begin
      ba = {qa[5:2], qa[1:0] ^ 2'(k)};
      chk(k == 0 ? "R2 first ready" : tg, {63'd0, rdy}, 64'd1);
      chk({tg, " cache-enable"}, {63'd0, cen}, {63'd0, (k == 0) && burst && !w});
      if (!w) begin
        chk(burst ? "R4 R5 burst data" : "R6 R7 R10 single data", rdata,
            mem[ba] & (burst ? 64'hFFFF_FFFF_FFFF_FFFF : mask64(bev)));
      end else begin
        wd = {32'hC0DE_0000 | 32'(ba), 32'h1357_0000 | 32'(k)};
        wdata = wd;
        wa[k] = ba;
        we[k] = burst ? wd : ((mem[ba] & ~mask64(bev)) | (wd & mask64(bev)));
      end
      if (inj >= 0 && k == inj + 1) begin
        chk("R11 error pulse", {63'd0, perr}, 64'd1);
        strobe = 1'b0;
      end else if (k == 0) begin
        chk("R12 no error on accepted strobe", {63'd0, perr}, 64'd0);
      end
      if (inj >= 0 && k == inj) begin
        strobe = 1'b1; qaddr = 29'h3F; wr = ~w;
      end
      @(negedge clk);
    end
    chk({tg, " R11 beat count"}, {63'd0, rdy}, 64'd0);
    if (w) begin
      for (int k = 0; k < nb; k++) chk({tg, " R4 memory word"}, mem[wa[k]], we[k]);
    end
    wr = 1'b0; be = 8'h00; ca = 1'b0;
  endtask

  initial begin
    for (int i = 0; i < 64; i++)
      mem[i] = {32'hD00D_0000 | 32'(i), 32'h5A00_0000 + 32'(i) * 32'h0101_0101};
    rst_n = 1'b0; strobe = 1'b0; qaddr = '0; be = '0; wr = 1'b0; ca = 1'b0; wdata = '0;
    repeat (3) @(negedge clk);
    chk("R1 ready in reset", {63'd0, rdy}, 64'd0);
    chk("R1 cache-enable in reset", {63'd0, cen}, 64'd0);
    chk("R1 error in reset", {63'd0, perr}, 64'd0);
    chk("R1 mem enable in reset", {63'd0, m_en}, 64'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 idle after release", {61'd0, rdy, m_en, perr}, 64'd0);

    // vector table, cycles back to back (R12)
    foreach (VECS[i]) run_cyc(VECS[i].qa, VECS[i].be, VECS[i].wr, VECS[i].ca, -1);

    // R11: strobe injected during beat 1 of a line fill
    run_cyc(6'h0C, 8'h01, 1'b0, 1'b1, 1);
    for (int j = 0; j < 3; j++) begin
      chk("R11 ignored strobe starts nothing", {62'd0, rdy, perr}, 64'd0);
      @(negedge clk);
    end

    // R1: reset in mid-burst
    strobe = 1'b1; qaddr = 29'h0D; be = 8'hFF; wr = 1'b0; ca = 1'b1;
    @(negedge clk);
    strobe = 1'b0;
    repeat (2) @(negedge clk);
    chk("R1 burst running before reset", {63'd0, rdy}, 64'd1);
    rst_n = 1'b0;
    #1;
    chk("R1 ready drops on reset", {63'd0, rdy}, 64'd0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 idle after second reset", {62'd0, rdy, m_en}, 64'd0);
    run_cyc(6'h0E, 8'h0F, 1'b0, 1'b1, -1);

    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    nchk++;
    nfail++;
    $display("FAIL watchdog expired act=%0d exp=0", 1);
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end

endmodule